// File: doc/BRIEF.md
# Command Ring Free-Space Monitor

This block watches a circular command ring. A consumer moves the head pointer and a producer moves the tail pointer. Before the producer writes, it asks the monitor for a number of bytes. The monitor then polls the head once per clock and computes how much room is left. It keeps a fixed guard gap between tail and head. It grants the request on the first poll that shows enough room.

A stall watchdog limits the wait. Its count restarts whenever a poll sees the head move. The block therefore reports a busy error only after the consumer has stopped advancing for a full window of polls, not after a fixed total time.

A drain request asks for the whole ring less the guard gap, which is met only once the ring has been consumed. The block also gives a registered empty flag and a waiting flag that shows a request is stalled. Memory access and the writing of command words happen elsewhere.

Top module: `rfm_ring_monitor`

## Requirements
- R1: Both pointers are masked before use. Bits at or above log2(ring size) are cleared, and the low ALIGN_BITS bits (2 by default) are cleared, so that byte pointers are treated as 4-byte aligned offsets into the ring.
- R2: Free space is computed as a signed value: masked head minus (masked tail plus 8). If this is negative, the ring size is added once. A result that is still negative counts as less than any request.
- R3: A request is accepted on a clock edge where req_valid_i is high and the block is idle. Each following edge is one poll. On the first poll whose free space is greater than or equal to the request, grant_o is high for the next cycle.
- R4: If the head stays the same, busy_err_o is high for one cycle after the POLL_LIMIT-th failing poll. The block then returns to idle without a grant.
- R5: A failing poll that sees a masked head different from the previous poll (or from the value at acceptance) restarts the window. The error then follows the POLL_LIMIT-th failing poll, counting that poll as the first.
- R6: waiting_o goes high after the first failing poll. It stays high while the request is stalled and is low in the cycle where grant_o or busy_err_o is high, and whenever the block is idle.
- R7: With req_drain_i high at acceptance, the requested amount is the ring size minus 8, and req_bytes_i is not used.
- R8: empty_o is high one cycle after an edge where the masked head equals the masked tail, and low otherwise.
- R9: A req_valid_i pulse that arrives while a request is in progress has no effect on the outcome or its timing.
- R10: During reset, grant_o, busy_err_o, waiting_o and empty_o are low.
- R11: grant_o and busy_err_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| head_i | input | PTR_W | Consumer (read) pointer, byte address |
| tail_i | input | PTR_W | Producer (write) pointer, byte address |
| ring_bytes_i | input | PTR_W+1 | Ring size in bytes, power of two, at least 16 |
| req_valid_i | input | 1 | Start strobe for a space request |
| req_drain_i | input | 1 | Ask for the whole ring less the guard gap |
| req_bytes_i | input | PTR_W+1 | Requested byte count |
| grant_o | output | 1 | One-cycle pulse: space is available |
| busy_err_o | output | 1 | One-cycle pulse: consumer stalled, request abandoned |
| waiting_o | output | 1 | A request is stalled |
| empty_o | output | 1 | Masked head equals masked tail |

## Verification
The bench builds the block with PTR_W = 6 and POLL_LIMIT = 12. With these values it can sweep every aligned head/tail pair for ring sizes of 16, 32 and 64 bytes, with dirty high and low pointer bits, and run each stalled request through to its error within a few cycles.

The small sizes make the wrap and the still-negative free-space case common in the sweep. The short window lets the restart-on-movement and late-grant timings be checked to the exact poll.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
   typedef enum logic [0:0] {
      RFM_IDLE = 1'b0,
      RFM_POLL = 1'b1
   } rfm_state_e;
endpackage

// File: rtl/rfm_ptr_mask.sv
module rfm_ptr_mask #(
   parameter int PTR_W      = 16,
   parameter int ALIGN_BITS = 2
) (
   input  logic [PTR_W-1:0] ptr_i,
   input  logic [PTR_W:0]   size_i,
   output logic [PTR_W-1:0] ptr_o
);
   localparam int SIZE_W = PTR_W + 1;

   logic [PTR_W-1:0] wrapped;

   // keep only the offset inside the ring
   assign wrapped = PTR_W'({1'b0, ptr_i} & (size_i - SIZE_W'(1)));

   generate
      if (ALIGN_BITS == 0) begin : g_no_align
         assign ptr_o = wrapped;
      end else begin : g_align
         localparam logic [PTR_W-1:0] LOW_CLR = ~PTR_W'((1 << ALIGN_BITS) - 1);
         assign ptr_o = wrapped & LOW_CLR;
      end
   endgenerate
endmodule

// File: rtl/rfm_space_calc.sv
module rfm_space_calc #(
   parameter int PTR_W       = 16,
   parameter int GUARD_BYTES = 8
) (
   input  logic [PTR_W-1:0] head_i,
   input  logic [PTR_W-1:0] tail_i,
   input  logic [PTR_W:0]   size_i,
   input  logic [PTR_W:0]   need_i,
   output logic             enough_o
);
   localparam int SPC_W = PTR_W + 3;

   logic signed [SPC_W-1:0] head_s, tail_s, size_s, need_s;
   logic signed [SPC_W-1:0] raw_s, room_s;

   assign head_s = $signed({3'b000, head_i});
   assign tail_s = $signed({3'b000, tail_i});
   assign size_s = $signed({2'b00, size_i});
   assign need_s = $signed({2'b00, need_i});

   // one wrap correction only; a still-negative result means no room
   assign raw_s    = head_s - (tail_s + SPC_W'(GUARD_BYTES));
   assign room_s   = (raw_s < 0) ? raw_s + size_s : raw_s;
   assign enough_o = (room_s >= need_s);
endmodule

// File: rtl/rfm_stall_wdog.sv
module rfm_stall_wdog #(
   parameter int POLL_LIMIT = 10000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic step_i,
   input  logic moved_i,
   output logic expire_o
);
   localparam int CNT_W = $clog2(POLL_LIMIT + 1);

   logic [CNT_W-1:0] cnt_q, cnt_nxt;

   // a poll that sees movement opens a new window and counts as its first
   assign cnt_nxt  = moved_i ? CNT_W'(1) : cnt_q + CNT_W'(1);
   assign expire_o = step_i && (cnt_nxt == CNT_W'(POLL_LIMIT));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= expire_o ? '0 : cnt_nxt;
      end
   end
endmodule

// File: rtl/rfm_ring_monitor.sv
module rfm_ring_monitor
   import rfm_pkg::*;
#(
   parameter int PTR_W       = 16,
   parameter int ALIGN_BITS  = 2,
   parameter int GUARD_BYTES = 8,
   parameter int POLL_LIMIT  = 10000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [PTR_W-1:0] head_i,
   input  logic [PTR_W-1:0] tail_i,
   input  logic [PTR_W:0]   ring_bytes_i,
   input  logic             req_valid_i,
   input  logic             req_drain_i,
   input  logic [PTR_W:0]   req_bytes_i,
   output logic             grant_o,
   output logic             busy_err_o,
   output logic             waiting_o,
   output logic             empty_o
);
   localparam int SIZE_W = PTR_W + 1;

   initial begin
      assert (PTR_W >= 4 && PTR_W <= 30)
         else $fatal(1, "rfm_ring_monitor: PTR_W out of range");
      assert (ALIGN_BITS >= 0 && ALIGN_BITS < PTR_W - 2)
         else $fatal(1, "rfm_ring_monitor: ALIGN_BITS out of range");
      assert (POLL_LIMIT >= 2)
         else $fatal(1, "rfm_ring_monitor: POLL_LIMIT must be at least 2");
      assert (GUARD_BYTES >= 0 && GUARD_BYTES < (1 << PTR_W))
         else $fatal(1, "rfm_ring_monitor: GUARD_BYTES out of range");
   end

   rfm_state_e       state_q;
   logic [PTR_W-1:0] head_m, tail_m, last_head_q;
   logic [PTR_W:0]   need_q;
   logic             enough, expire, accept, poll_fail, moved;
   logic             grant_q, err_q, wait_q, empty_q;

   rfm_ptr_mask #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_head_mask (
      .ptr_i (head_i),
      .size_i(ring_bytes_i),
      .ptr_o (head_m)
   );

   rfm_ptr_mask #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_tail_mask (
      .ptr_i (tail_i),
      .size_i(ring_bytes_i),
      .ptr_o (tail_m)
   );

   rfm_space_calc #(.PTR_W(PTR_W), .GUARD_BYTES(GUARD_BYTES)) u_space (
      .head_i  (head_m),
      .tail_i  (tail_m),
      .size_i  (ring_bytes_i),
      .need_i  (need_q),
      .enough_o(enough)
   );

   assign accept    = (state_q == RFM_IDLE) && req_valid_i;
   assign poll_fail = (state_q == RFM_POLL) && !enough;
   assign moved     = (head_m != last_head_q);

   rfm_stall_wdog #(.POLL_LIMIT(POLL_LIMIT)) u_wdog (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (accept),
      .step_i  (poll_fail),
      .moved_i (moved),
      .expire_o(expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= RFM_IDLE;
         last_head_q <= '0;
         need_q      <= '0;
         grant_q     <= 1'b0;
         err_q       <= 1'b0;
         wait_q      <= 1'b0;
         empty_q     <= 1'b0;
      end else begin
         grant_q <= 1'b0;
         err_q   <= 1'b0;
         empty_q <= (head_m == tail_m);
         case (state_q)
            RFM_IDLE: begin
               if (req_valid_i) begin
                  need_q      <= req_drain_i ? ring_bytes_i - SIZE_W'(GUARD_BYTES)
                                             : req_bytes_i;
                  last_head_q <= head_m;
                  state_q     <= RFM_POLL;
               end
            end
            RFM_POLL: begin
               last_head_q <= head_m;
               if (enough) begin
                  grant_q <= 1'b1;
                  wait_q  <= 1'b0;
                  state_q <= RFM_IDLE;
               end else if (expire) begin
                  err_q   <= 1'b1;
                  wait_q  <= 1'b0;
                  state_q <= RFM_IDLE;
               end else begin
                  wait_q  <= 1'b1;
               end
            end
            default: state_q <= RFM_IDLE;
         endcase
      end
   end

   assign grant_o    = grant_q;
   assign busy_err_o = err_q;
   assign waiting_o  = wait_q;
   assign empty_o    = empty_q;
endmodule

// File: rtl/rfm_ring_monitor_chk.sv
module rfm_ring_monitor_chk #(
   parameter int PTR_W      = 16,
   parameter int ALIGN_BITS = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [PTR_W-1:0] head_i,
   input logic [PTR_W-1:0] tail_i,
   input logic [PTR_W:0]   ring_bytes_i,
   input logic             grant_o,
   input logic             busy_err_o,
   input logic             waiting_o,
   input logic             empty_o
);
   logic [PTR_W:0] span;
   logic           same_slot;

   assign span      = ({1'b0, head_i ^ tail_i}) & (ring_bytes_i - (PTR_W+1)'(1));
   assign same_slot = ((span >> ALIGN_BITS) == '0);

   AST_OUTCOME_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(grant_o && busy_err_o)); // R11
   AST_GRANT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o |=> !grant_o); // R11
   AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_err_o |=> !busy_err_o); // R11
   AST_WAIT_LOW_ON_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o || busy_err_o) |-> !waiting_o); // R6
   AST_EMPTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      same_slot |=> empty_o); // R8
   AST_EMPTY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !same_slot |=> !empty_o); // R8
   AST_ERR_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_err_o |-> $past(waiting_o)); // R4
endmodule

bind rfm_ring_monitor rfm_ring_monitor_chk #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .head_i      (head_i),
   .tail_i      (tail_i),
   .ring_bytes_i(ring_bytes_i),
   .grant_o     (grant_o),
   .busy_err_o  (busy_err_o),
   .waiting_o   (waiting_o),
   .empty_o     (empty_o)
);

// File: tb/tb_rfm_ring_monitor.sv
module tb_rfm_ring_monitor;
   localparam int PW    = 6;
   localparam int LIMIT = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] head = '0, tail = '0;
   logic [PW:0]   ring_bytes = 7'd32;
   logic          req_valid = 1'b0, req_drain = 1'b0;
   logic [PW:0]   req_bytes = '0;
   logic          grant, busy_err, waiting, empty;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   rfm_ring_monitor #(.PTR_W(PW), .POLL_LIMIT(LIMIT)) dut (
      .clk_i(clk), .rst_ni(rst_n), .head_i(head), .tail_i(tail),
      .ring_bytes_i(ring_bytes), .req_valid_i(req_valid), .req_drain_i(req_drain),
      .req_bytes_i(req_bytes), .grant_o(grant), .busy_err_o(busy_err),
      .waiting_o(waiting), .empty_o(empty)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int mask_ptr(input int p, input int sz);
      return p & (sz - 1) & ~3;
   endfunction

   function automatic int room(input int h, input int t, input int sz);
      int s;
      s = mask_ptr(h, sz) - (mask_ptr(t, sz) + 8);
      if (s < 0) s += sz;
      return s;
   endfunction

   // pulses the start strobe; returns at the negedge after the accepting edge
   task automatic start_req(input int nbytes, input bit drain);
      @(negedge clk);
      req_valid = 1'b1;
      req_bytes = (PW+1)'(nbytes);
      req_drain = drain;
      @(negedge clk);
      req_valid = 1'b0;
      req_drain = 1'b0;
   endtask

   // waits poll by poll (first poll = k0) until an outcome pulse; returns poll index
   task automatic run_to_outcome(input int k0, output int k_out, output bit got_grant);
      int k;
      k = k0;
      got_grant = 1'b0;
      forever begin
         @(negedge clk);
         if (grant) begin got_grant = 1'b1; break; end
         if (busy_err) break;
         if (k > 3 * LIMIT) break;
         k++;
      end
      k_out = k;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int  kk;
      bit  gg;
      // R10: reset state
      repeat (3) @(negedge clk);
      check(!grant && !busy_err && !waiting && !empty, "R10 outputs low in reset",
            {grant, busy_err, waiting, empty}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep: R1 R2 R3 R4 R8
      for (int si = 0; si < 3; si++) begin
         int sz;
         sz = 16 << si;
         ring_bytes = (PW+1)'(sz);
         for (int h = 0; h < sz; h += 4) begin
            for (int t = 0; t < sz; t += 4) begin
               for (int ni = 0; ni < 2; ni++) begin
                  int hd, td, need, s;
                  hd   = ((h | 1) + ((sz < 64) ? sz : 0)) & 63;
                  td   = t | 2;
                  need = (ni == 0) ? 4 : sz / 2;
                  head = PW'(hd);
                  tail = PW'(td);
                  s    = room(hd, td, sz);
                  start_req(need, 1'b0);
                  check(empty == (h == t), "R8/R1 empty after masking", empty, h == t);
                  @(negedge clk); // poll 1
                  if (s >= need) begin
                     check(grant && !busy_err, "R3/R2 grant on first poll", grant, 1);
                     @(negedge clk);
                     check(!grant, "R11 grant single cycle", grant, 0);
                  end else begin
                     check(!grant && waiting, "R2/R6 stalled on first poll",
                           {grant, waiting}, 1);
                     if (busy_err) kk = 1;
                     else run_to_outcome(2, kk, gg);
                     check(kk == LIMIT && busy_err, "R4 error at poll limit", kk, LIMIT);
                     @(negedge clk);
                  end
               end
            end
         end
      end

      // R5: head movement restarts the window
      ring_bytes = 7'd32;
      tail = 6'd0; head = 6'd8;
      start_req(16, 1'b0);
      repeat (5) @(negedge clk); // polls 1..5
      check(waiting && !busy_err, "R6 waiting while stalled", waiting, 1);
      head = 6'd12;
      run_to_outcome(6, kk, gg);
      check(!gg && kk == 5 + LIMIT, "R5 error after restart", kk, 5 + LIMIT);
      @(negedge clk);
      check(!waiting, "R6 waiting low when idle", waiting, 0);

      // R3: late grant when the head moves far enough
      head = 6'd8;
      start_req(16, 1'b0);
      repeat (3) @(negedge clk);
      head = 6'd28; // room 20
      @(negedge clk);
      check(grant && !waiting, "R3 grant on poll after space appears", grant, 1);
      @(negedge clk);

      // R9: strobe during a stall is ignored
      head = 6'd8;
      start_req(16, 1'b0);
      @(negedge clk); @(negedge clk); // polls 1,2
      req_valid = 1'b1; req_bytes = '0;
      @(negedge clk); // poll 3
      req_valid = 1'b0;
      if (busy_err || grant) begin kk = 3; gg = grant; end
      else run_to_outcome(4, kk, gg);
      check(!gg && kk == LIMIT, "R9 request during stall ignored", kk, LIMIT);
      @(negedge clk);

      // R7: drain on an empty ring grants, on a busy ring stalls
      head = 6'd20; tail = 6'd20;
      start_req(63, 1'b1);
      @(negedge clk);
      check(grant, "R7 drain on empty ring grants", grant, 1);
      @(negedge clk);
      head = 6'd20; tail = 6'd24; // room 20 < 24
      start_req(0, 1'b1);
      @(negedge clk);
      check(!grant && waiting, "R7 drain on busy ring waits", grant, 0);
      head = 6'd24; // now equal: room 24
      @(negedge clk);
      check(grant, "R7 drain grants once consumed", grant, 1);
      @(negedge clk);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule